// File: doc/BRIEF.md
# SDRAM Command Turnaround Timer

This block sits between the command scheduler of an SDRAM controller and the memory command bus. It receives candidate commands (ACTIVE, READ, WRITE, PRECHARGE, each with a bank number) through a valid/ready handshake. It holds each command back until every minimum spacing that applies to it has run out. The spacings are the read-to-read/precharge gap, the write-to-anything gap, the read-to-write gap, and a per-bank wait from ACTIVE to the first access. A command that is free to go leaves on the output in the same cycle it is presented.

The three gaps and the burst length are set by one 32-bit configuration word, written through a simple write port and readable at all times. Until the word has been written once, the block accepts no command. Each gap counter loads when its command issues and counts down, so a later command of a blocked kind waits only as long as the gap still has to run.

Top module: `sdram_cmd_gap_timer`

## Requirements
- R1: Out of reset `cfg_rdata` reads zero and `cmd_ready` stays low for every command type until the first cycle after `cfg_we` has been high once.
- R2: On a `cfg_we` cycle the configuration takes `cfg_wdata[31:16]`, laid out as follows: read-to-read/precharge gap in bits 31:28, write-to-any gap in 27:24, read-to-write gap in 23:20, burst length minus one in 19:16. `cfg_rdata` then returns those 16 bits in place, and bits 15:0 always read back as zero whatever was written to them.
- R3: If a READ issues in cycle t, no READ or PRECHARGE issues before cycle t+N, where N is the read-to-read/precharge field (0 or 1 means the next cycle).
- R4: If a WRITE issues in cycle t, no READ, WRITE or PRECHARGE issues before cycle t+N, where N is the write-to-any field.
- R5: If a READ issues in cycle t, no WRITE issues before cycle t+N, where N is the read-to-write field. This gap keeps running while other commands issue in between.
- R6: If an ACTIVE to bank b issues in cycle t, no READ or WRITE to bank b issues before cycle t+ACT_GAP (default 2). Accesses to other banks are not delayed by it.
- R7: Command type encoding is 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE. Once configured, ACTIVE is always ready, and any command whose gaps have elapsed is ready in the same cycle. `out_valid` equals `cmd_valid && cmd_ready` combinationally, with `out_type`/`out_bank` copied from the inputs. Each command issues at exactly the earliest cycle the gaps allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| cmd_valid | input | 1 | Candidate command present |
| cmd_type | input | 2 | Command type (0 ACT, 1 RD, 2 WR, 3 PRE) |
| cmd_bank | input | 2 | Target bank |
| cmd_ready | output | 1 | Command may issue this cycle |
| out_valid | output | 1 | Command issued on the memory bus |
| out_type | output | 2 | Issued command type |
| out_bank | output | 2 | Issued command bank |

## Verification
The bench sends a back-to-back stream and measures the exact spacing of each issue, so a counter that is off by one (spacing N+1 or N-1) shows up at once. One case has a WRITE that follows a READ with a PRECHARGE in between: a design that restarted or dropped the read-to-write gap on the intervening command would let the WRITE out early. Two ACTIVEs go to different banks back to back and a READ follows to the first bank. A shared activate timer would stall that READ by one cycle. A zero configuration must give single-cycle spacing, the unconfigured state must refuse ACTIVE as well, and a write of ones to the low configuration bits must read back as zero.

// File: rtl/sdram_gap_pkg.sv
package sdram_gap_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    localparam int GAP_W = 4;

    typedef struct packed {
        logic [GAP_W-1:0] rd2rp;
        logic [GAP_W-1:0] wr2any;
        logic [GAP_W-1:0] rd2wr;
        logic [GAP_W-1:0] blen;
    } gap_cfg_t;

    function automatic logic [GAP_W-1:0] reload_of(input logic [GAP_W-1:0] gap);
        return (gap == '0) ? '0 : gap - 1'b1;
    endfunction

endpackage

// File: rtl/gap_cfg_reg.sv
module gap_cfg_reg
    import sdram_gap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [15:0]          wdata_hi,
    output logic [GAP_W-1:0]     rd2rp,
    output logic [GAP_W-1:0]     wr2any,
    output logic [GAP_W-1:0]     rd2wr,
    output logic                 done,
    output logic [31:0]          rdata
);

    typedef struct packed {
        gap_cfg_t cfg;
        logic     done;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg  = gap_cfg_t'(wdata_hi);
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd2rp  = st_q.cfg.rd2rp;
    assign wr2any = st_q.cfg.wr2any;
    assign rd2wr  = st_q.cfg.rd2wr;
    assign done   = st_q.done;
    assign rdata  = {st_q.cfg, 16'h0000};

    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R1

endmodule

// File: rtl/gap_down_counter.sv
module gap_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                st_d.cnt = load_val;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = (st_q.cnt == '0);

    AST_CNT_REACHES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired && st_q.cnt == W'(1)) |=> expired); // R3

endmodule

// File: rtl/sdram_cmd_gap_timer.sv
module sdram_cmd_gap_timer
    import sdram_gap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ACT_GAP   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_type,
    input  logic [1:0]  cmd_bank,
    output logic        cmd_ready,
    output logic        out_valid,
    output logic [1:0]  out_type,
    output logic [1:0]  out_bank
);

    localparam int ACT_W = $clog2(ACT_GAP + 1);
    localparam logic [ACT_W-1:0] ACT_RELOAD = ACT_W'(ACT_GAP - 1);

    logic [GAP_W-1:0] rd2rp, wr2any, rd2wr;
    logic             cfg_done;
    logic             unused_cfg_low;

    assign unused_cfg_low = ^cfg_wdata[15:0];

    gap_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata_hi (cfg_wdata[31:16]),
        .rd2rp    (rd2rp),
        .wr2any   (wr2any),
        .rd2wr    (rd2wr),
        .done     (cfg_done),
        .rdata    (cfg_rdata)
    );

    cmd_e type_in;
    logic fire;
    logic rd_exp, wr_exp, r2w_exp;
    logic [NUM_BANKS-1:0] act_exp;
    logic bank_ok;

    assign type_in = cmd_e'(cmd_type);
    assign bank_ok = act_exp[cmd_bank];

    always_comb begin
        cmd_ready = 1'b0;
        if (cfg_done) begin
            unique case (type_in)
                CMD_ACT: cmd_ready = 1'b1;
                CMD_RD:  cmd_ready = rd_exp && wr_exp && bank_ok;
                CMD_WR:  cmd_ready = wr_exp && r2w_exp && bank_ok;
                CMD_PRE: cmd_ready = rd_exp && wr_exp;
                default: cmd_ready = 1'b0;
            endcase
        end
    end

    assign fire      = cmd_valid && cmd_ready;
    assign out_valid = fire;
    assign out_type  = cmd_type;
    assign out_bank  = cmd_bank;

    gap_down_counter #(.W(GAP_W)) u_rd_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire && type_in == CMD_RD),
        .load_val (reload_of(rd2rp)),
        .expired  (rd_exp)
    );

    gap_down_counter #(.W(GAP_W)) u_wr_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire && type_in == CMD_WR),
        .load_val (reload_of(wr2any)),
        .expired  (wr_exp)
    );

    gap_down_counter #(.W(GAP_W)) u_r2w_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire && type_in == CMD_RD),
        .load_val (reload_of(rd2wr)),
        .expired  (r2w_exp)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gap_down_counter #(.W(ACT_W)) u_act_gap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (fire && type_in == CMD_ACT && cmd_bank == 2'(b)),
            .load_val (ACT_RELOAD),
            .expired  (act_exp[b])
        );
    end

    AST_NO_CMD_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !cmd_ready); // R1

    AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && type_in == CMD_RD && rd2rp >= 4'd2)
            |=> !(out_valid && (out_type == CMD_RD || out_type == CMD_PRE))); // R3

    AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && type_in == CMD_WR && wr2any >= 4'd2) |=> !out_valid
            || out_type == CMD_ACT); // R4

    AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && type_in == CMD_RD && rd2wr >= 4'd2)
            |=> !(out_valid && out_type == CMD_WR)); // R5

    if (ACT_GAP >= 2) begin : g_act_chk
        AST_ACT_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && type_in == CMD_ACT)
                |=> !(out_valid && out_bank == $past(cmd_bank)
                      && (out_type == CMD_RD || out_type == CMD_WR))); // R6
    end

    AST_OUT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cmd_valid); // R7

endmodule

// File: tb/tb_sdram_cmd_gap_timer.sv
module tb_sdram_cmd_gap_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic [1:0]  cmd_bank = '0;
    logic        cmd_ready;
    logic        out_valid;
    logic [1:0]  out_type;
    logic [1:0]  out_bank;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int prev = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_gap_timer dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
        .cmd_ready(cmd_ready), .out_valid(out_valid),
        .out_type(out_type), .out_bank(out_bank)
    );

    // type(2) bank(2) expected spacing(4); config RR=4 WA=6 RW=7
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 2'd0, 4'd1},  // ACT b0
        {2'd1, 2'd0, 4'd2},  // READ b0 after ACT: R6
        {2'd1, 2'd0, 4'd4},  // READ after READ: R3
        {2'd2, 2'd0, 4'd7},  // WRITE after READ: R5
        {2'd3, 2'd0, 4'd6},  // PRE after WRITE: R4
        {2'd0, 2'd1, 4'd1},  // ACT b1 free: R7
        {2'd0, 2'd2, 4'd1},  // ACT b2 free: R7
        {2'd1, 2'd1, 4'd1},  // READ b1 not held by b2: R6
        {2'd3, 2'd2, 4'd4},  // PRE after READ: R3
        {2'd2, 2'd1, 4'd3},  // WRITE, gap from READ spans PRE: R5
        {2'd1, 2'd2, 4'd6},  // READ after WRITE: R4
        {2'd0, 2'd3, 4'd1},  // ACT b3
        {2'd2, 2'd3, 4'd6}   // WRITE: READ->WRITE binds over ACT: R5
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [1:0] t, input logic [1:0] b,
                         input int exp_gap, input string req);
        int waits;
        int gap;
        waits = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_type = t;
        cmd_bank = b;
        forever begin
            #1;
            if (cmd_ready) break;
            if (out_valid) check(0, "R7", "out_valid while stalled", 1, 0);
            waits++;
            if (waits > 40) break;
            @(negedge clk);
        end
        gap = cyc - prev;
        prev = cyc;
        check(out_valid && out_type == t && out_bank == b, "R7", "issue copy",
              {out_valid, out_type, out_bank}, {1'b1, t, b});
        check(gap == exp_gap, req, "issue spacing", gap, exp_gap);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state: unconfigured block refuses even ACTIVE
        cmd_valid = 1'b1;
        cmd_type = 2'd0;
        repeat (3) begin
            @(negedge clk); #1;
            check(!cmd_ready && !out_valid, "R1", "ready before config", cmd_ready, 0);
        end
        check(cfg_rdata == 32'h0, "R1", "rdata after reset", cfg_rdata, 0);
        cmd_valid = 1'b0;

        // readback: low half masked
        cfg_write(32'h4677_ABCD);
        #1;
        check(cfg_rdata == 32'h4677_0000, "R2", "readback", cfg_rdata, 32'h4677_0000);

        // stimulus table
        @(negedge clk);
        prev = cyc;
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]), "R3/R4/R5/R6 vec");
        end

        // zero gaps: back-to-back issue
        cfg_write(32'h0000_0000);
        check(cfg_rdata == 32'h0, "R2", "zero config readback", cfg_rdata, 0);
        repeat (12) @(posedge clk);
        @(negedge clk);
        prev = cyc;
        issue(2'd1, 2'd0, 1, "R3 zero gap read");
        issue(2'd1, 2'd0, 1, "R3 zero gap read-read");
        issue(2'd2, 2'd0, 1, "R5 zero gap read-write");
        issue(2'd2, 2'd0, 1, "R4 zero gap write-write");

        // low bits written as ones read as zero
        cfg_write(32'hFFFF_FFFF);
        check(cfg_rdata == 32'hFFFF_0000, "R2", "low bits ignored", cfg_rdata, 32'hFFFF_0000);

        // maximum gap
        repeat (20) @(posedge clk);
        @(negedge clk);
        prev = cyc;
        issue(2'd1, 2'd2, 1, "R3 max first");
        issue(2'd3, 2'd2, 15, "R3 max gap precharge");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule